// File: doc/BRIEF.md
# Dual-Issue Pair Detector

This block sits after fetch in an in-order core whose instruction encoding carries no flag marking instructions that may run side by side. It receives two adjacent fetched words, a leading word and the word after it, each with a valid flag. It decides whether the two may leave together as a two-wide bundle. The decision acts as a derived bundle-continuation bit. Each word is sorted by its major opcode into a class. The class says whether the word may take the first slot, the second slot, both, or neither. The detector then compares the register indices of the two words to find clashes.

The outcome and the register indices used for the comparison are registered once and presented one cycle after the inputs. When pairing is refused, the issue logic sends the leading word alone and offers the following word as the next leading candidate. This keeps program order. A bundle never holds more than two words, so a third word is never considered. Only full 32-bit words can pair. A compressed (16-bit) word always goes out on its own.

Top module: `pair_issue_detector`

## Requirements
- R1: A synchronous active-high reset clears `pair_ok` and all four reported indices to zero at the next clock edge, whatever the inputs are.
- R2: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge.
- R3: Register fields are rd = bits 11:7, rs1 = bits 19:15 and rs2 = bits 24:20. Each reported index equals its field when the word's class uses that register, and is 0 otherwise. An invalid word reports zeros.
- R4: The class comes from bits 6:0. 0110011 is register ALU (uses rd, rs1, rs2). 0010011 is immediate ALU (uses rd, rs1). 0000011 is load (uses rd, rs1). 0100011 is store (uses rs1, rs2). 1100011 is branch (uses rs1, rs2). 1110011 is system (uses rd, rs1). All six may lead a bundle. Any other opcode, and the all-zero or all-ones word, is unclassified and can take neither slot.
- R5: Only register ALU and immediate ALU words may take the second slot. A following load, store, branch or system word never pairs.
- R6: A word whose bits 1:0 are not 11 is compressed. A pair containing a compressed word never pairs.
- R7: Pairing is refused when either used source of the following word equals the nonzero destination of the leading word (read after write).
- R8: Pairing is refused when both words write the same nonzero destination (write after write).
- R9: A leading destination of register 0 never blocks pairing.
- R10: If either valid flag is low, `pair_ok` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lead_valid | input | 1 | Leading word present |
| lead_instr | input | 32 | Leading instruction word |
| follow_valid | input | 1 | Following word present |
| follow_instr | input | 32 | Following instruction word |
| pair_ok | output | 1 | Both words may issue together |
| lead_rd | output | 5 | Destination index of the leading word (0 if none) |
| follow_rd | output | 5 | Destination index of the following word (0 if none) |
| follow_rs1 | output | 5 | First source index of the following word (0 if none) |
| follow_rs2 | output | 5 | Second source index of the following word (0 if none) |

## Verification
Several vetoes can apply in the same cycle. A read-after-write clash and a write-after-write clash can both be present, and either can coincide with a slot-class refusal or a compressed word. The sweep covers every pairing of eight opcode kinds with register indices drawn from 0 to 3 in all four compared fields. This produces every overlap, including the cases where register 0 hides a clash. Each vector is judged by a bench model that derives `pair_ok` and the four indices from the class rules and register comparisons. The failure is attributed to the first veto that applies.

// File: rtl/pairdet_pkg.sv
package pairdet_pkg;

    parameter int unsigned ILEN = 32;
    parameter int unsigned RIDX = 5;

    localparam int unsigned OPC_W   = 7;
    localparam int unsigned RD_LSB  = 7;
    localparam int unsigned RS1_LSB = 15;
    localparam int unsigned RS2_LSB = 20;

    localparam logic [OPC_W-1:0] OPC_ALU_RR = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_ALU_RI = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_SYSTEM = 7'b1110011;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_ALU_RR,
        CL_ALU_RI,
        CL_LOAD,
        CL_STORE,
        CL_BRANCH,
        CL_SYSTEM
    } op_class_e;

    typedef struct packed {
        op_class_e       cls;
        logic            can_lead;
        logic            can_follow;
        logic [RIDX-1:0] rd;
        logic [RIDX-1:0] rs1;
        logic [RIDX-1:0] rs2;
    } slot_info_t;

    typedef struct packed {
        logic            ok;
        logic [RIDX-1:0] lead_rd;
        logic [RIDX-1:0] follow_rd;
        logic [RIDX-1:0] follow_rs1;
        logic [RIDX-1:0] follow_rs2;
    } pair_result_t;

    function automatic op_class_e classify(input logic vld, input logic [ILEN-1:0] w);
        op_class_e c;
        c = CL_NONE;
        if (vld && (w[1:0] == 2'b11) && (w != '0) && (w != '1)) begin
            unique case (w[OPC_W-1:0])
                OPC_ALU_RR: c = CL_ALU_RR;
                OPC_ALU_RI: c = CL_ALU_RI;
                OPC_LOAD:   c = CL_LOAD;
                OPC_STORE:  c = CL_STORE;
                OPC_BRANCH: c = CL_BRANCH;
                OPC_SYSTEM: c = CL_SYSTEM;
                default:    c = CL_NONE;
            endcase
        end
        return c;
    endfunction

    function automatic logic uses_rd(input op_class_e c);
        return (c == CL_ALU_RR) || (c == CL_ALU_RI) || (c == CL_LOAD) || (c == CL_SYSTEM);
    endfunction

    function automatic logic uses_rs1(input op_class_e c);
        return c != CL_NONE;
    endfunction

    function automatic logic uses_rs2(input op_class_e c);
        return (c == CL_ALU_RR) || (c == CL_STORE) || (c == CL_BRANCH);
    endfunction

endpackage

// File: rtl/pd_slot_decode.sv
module pd_slot_decode
    import pairdet_pkg::*;
(
    input  logic            valid,
    input  logic [ILEN-1:0] instr,
    output slot_info_t      info
);

    op_class_e cls;

    always_comb begin
        cls             = classify(valid, instr);
        info.cls        = cls;
        info.can_lead   = (cls != CL_NONE);
        info.can_follow = (cls == CL_ALU_RR) || (cls == CL_ALU_RI);
        info.rd         = uses_rd(cls)  ? instr[RD_LSB  +: RIDX] : '0;
        info.rs1        = uses_rs1(cls) ? instr[RS1_LSB +: RIDX] : '0;
        info.rs2        = uses_rs2(cls) ? instr[RS2_LSB +: RIDX] : '0;
    end

endmodule

// File: rtl/pd_clash_check.sv
module pd_clash_check
    import pairdet_pkg::*;
(
    input  logic [RIDX-1:0] lead_rd,
    input  logic [RIDX-1:0] follow_rd,
    input  logic [RIDX-1:0] follow_rs1,
    input  logic [RIDX-1:0] follow_rs2,
    output logic            raw_hit,
    output logic            waw_hit
);

    logic lead_writes;

    always_comb begin
        lead_writes = (lead_rd != '0);
        raw_hit     = lead_writes && ((follow_rs1 == lead_rd) || (follow_rs2 == lead_rd));
        waw_hit     = lead_writes && (follow_rd == lead_rd);
    end

endmodule

// File: rtl/pair_issue_detector.sv
module pair_issue_detector
    import pairdet_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            lead_valid,
    input  logic [ILEN-1:0] lead_instr,
    input  logic            follow_valid,
    input  logic [ILEN-1:0] follow_instr,
    output logic            pair_ok,
    output logic [RIDX-1:0] lead_rd,
    output logic [RIDX-1:0] follow_rd,
    output logic [RIDX-1:0] follow_rs1,
    output logic [RIDX-1:0] follow_rs2
);

    localparam int unsigned NSLOT = 2;

    logic            slot_vld  [NSLOT];
    logic [ILEN-1:0] slot_word [NSLOT];
    slot_info_t      slot_info [NSLOT];

    assign slot_vld[0]  = lead_valid;
    assign slot_vld[1]  = follow_valid;
    assign slot_word[0] = lead_instr;
    assign slot_word[1] = follow_instr;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        pd_slot_decode u_dec (
            .valid (slot_vld[g]),
            .instr (slot_word[g]),
            .info  (slot_info[g])
        );
    end

    logic raw_hit, waw_hit;

    pd_clash_check u_clash (
        .lead_rd    (slot_info[0].rd),
        .follow_rd  (slot_info[1].rd),
        .follow_rs1 (slot_info[1].rs1),
        .follow_rs2 (slot_info[1].rs2),
        .raw_hit    (raw_hit),
        .waw_hit    (waw_hit)
    );

    pair_result_t res_d, res_q;

    always_comb begin
        res_d.ok         = slot_info[0].can_lead && slot_info[1].can_follow && !raw_hit && !waw_hit;
        res_d.lead_rd    = slot_info[0].rd;
        res_d.follow_rd  = slot_info[1].rd;
        res_d.follow_rs1 = slot_info[1].rs1;
        res_d.follow_rs2 = slot_info[1].rs2;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign pair_ok    = res_q.ok;
    assign lead_rd    = res_q.lead_rd;
    assign follow_rd  = res_q.follow_rd;
    assign follow_rs1 = res_q.follow_rs1;
    assign follow_rs2 = res_q.follow_rs2;

endmodule

// File: rtl/pd_checker.sv
module pd_checker
    import pairdet_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            lead_valid,
    input logic [1:0]      lead_lo2,
    input logic            follow_valid,
    input logic [OPC_W-1:0] follow_opc,
    input logic            pair_ok,
    input logic [RIDX-1:0] lead_rd,
    input logic [RIDX-1:0] follow_rd,
    input logic [RIDX-1:0] follow_rs1,
    input logic [RIDX-1:0] follow_rs2
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pair_ok && lead_rd == '0 && follow_rd == '0));

    // R10
    invalid_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!(lead_valid && follow_valid)) |-> !pair_ok);

    // R6
    compressed_lead_chk: assert property (@(posedge clk) disable iff (rst)
        $past(lead_valid && lead_lo2 != 2'b11) |-> !pair_ok);

    // R5
    load_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $past(follow_valid && follow_opc == OPC_LOAD) |-> !pair_ok);

    // R7
    raw_clash_chk: assert property (@(posedge clk) disable iff (rst)
        pair_ok |-> !(lead_rd != '0 && (follow_rs1 == lead_rd || follow_rs2 == lead_rd)));

    // R8
    waw_clash_chk: assert property (@(posedge clk) disable iff (rst)
        pair_ok |-> !(lead_rd != '0 && follow_rd == lead_rd));

endmodule

bind pair_issue_detector pd_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .lead_valid   (lead_valid),
    .lead_lo2     (lead_instr[1:0]),
    .follow_valid (follow_valid),
    .follow_opc   (follow_instr[6:0]),
    .pair_ok      (pair_ok),
    .lead_rd      (lead_rd),
    .follow_rd    (follow_rd),
    .follow_rs1   (follow_rs1),
    .follow_rs2   (follow_rs2)
);

// File: tb/tb_pair_issue_detector.sv
`timescale 1ns/1ps
module tb_pair_issue_detector;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lead_valid = 1'b0;
    logic [31:0] lead_instr = '0;
    logic        follow_valid = 1'b0;
    logic [31:0] follow_instr = '0;
    logic        pair_ok;
    logic [4:0]  lead_rd, follow_rd, follow_rs1, follow_rs2;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pair_issue_detector dut (
        .clk(clk), .rst(rst),
        .lead_valid(lead_valid), .lead_instr(lead_instr),
        .follow_valid(follow_valid), .follow_instr(follow_instr),
        .pair_ok(pair_ok), .lead_rd(lead_rd), .follow_rd(follow_rd),
        .follow_rs1(follow_rs1), .follow_rs2(follow_rs2)
    );

    // kinds: 0 reg ALU, 1 imm ALU, 2 load, 3 store, 4 branch, 5 system, 6 unknown, 7 compressed
    function automatic logic [6:0] kind_opc(input int k);
        case (k)
            0: return 7'b0110011;
            1: return 7'b0010011;
            2: return 7'b0000011;
            3: return 7'b0100011;
            4: return 7'b1100011;
            5: return 7'b1110011;
            6: return 7'b1101111;
            default: return 7'b0110001;
        endcase
    endfunction

    function automatic bit k_rd(input int k);  return k == 0 || k == 1 || k == 2 || k == 5; endfunction
    function automatic bit k_rs1(input int k); return k <= 5; endfunction
    function automatic bit k_rs2(input int k); return k == 0 || k == 3 || k == 4; endfunction

    function automatic logic [31:0] mk(input int k, input int rd, input int rs1, input int rs2);
        return {7'h00, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), kind_opc(k)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input bit lv, input logic [31:0] li, input bit fv, input logic [31:0] fi);
        lead_valid = lv; lead_instr = li; follow_valid = fv; follow_instr = fi;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with a pairable input present
        lead_valid = 1; lead_instr = mk(0, 1, 2, 3);
        follow_valid = 1; follow_instr = mk(1, 4, 5, 0);
        repeat (2) @(negedge clk);
        check("R1 pair_ok in reset", 32'(pair_ok), 0);
        check("R1 indices in reset", {12'h0, lead_rd, follow_rd, follow_rs1, follow_rs2}, 0);
        rst = 0;

        // R2/R3: one-cycle latency and field extraction with high indices
        apply(1, mk(0, 31, 2, 3), 1, mk(0, 30, 29, 28));
        check("R2 pair_ok latency", 32'(pair_ok), 1);
        check("R3 fields", {12'h0, lead_rd, follow_rd, follow_rs1, follow_rs2},
              {12'h0, 5'd31, 5'd30, 5'd29, 5'd28});
        apply(1, mk(0, 31, 2, 3), 1, mk(0, 30, 31, 28));
        check("R7 high-index RAW", 32'(pair_ok), 0);

        // R10: valid combinations on an otherwise pairable pair
        for (int v = 0; v < 4; v++) begin
            apply(v[0], mk(1, 6, 7, 0), v[1], mk(0, 8, 9, 10));
            check("R10 valid gating", 32'(pair_ok), (v == 3) ? 1 : 0);
            check("R3 invalid word reports zero",
                  {12'h0, lead_rd, follow_rd, follow_rs1, follow_rs2},
                  {12'h0, v[0] ? 5'd6 : 5'd0, v[1] ? 5'd8 : 5'd0,
                   v[1] ? 5'd9 : 5'd0, v[1] ? 5'd10 : 5'd0});
        end

        // R4/R5: all-zero and all-ones words are unclassified
        apply(1, 32'h0, 1, mk(0, 8, 9, 10));
        check("R4 all-zero lead", 32'(pair_ok), 0);
        apply(1, mk(0, 1, 2, 3), 1, 32'hFFFF_FFFF);
        check("R5 all-ones follow", 32'(pair_ok), 0);
        check("R3 all-ones follow fields", {17'h0, follow_rd, follow_rs1, follow_rs2}, 0);

        // Sweep: kinds x kinds x register indices 0..3
        for (int ka = 0; ka < 8; ka++)
            for (int kb = 0; kb < 8; kb++)
                for (int ra = 0; ra < 4; ra++)
                    for (int rb = 0; rb < 4; rb++)
                        for (int s1 = 0; s1 < 4; s1++)
                            for (int s2 = 0; s2 < 4; s2++) begin
                                int erd, ebd, eb1, eb2;
                                bit raw, waw, ok;
                                string tag;
                                apply(1, mk(ka, ra, 5, 6), 1, mk(kb, rb, s1, s2));
                                erd = k_rd(ka) ? ra : 0;
                                ebd = k_rd(kb) ? rb : 0;
                                eb1 = k_rs1(kb) ? s1 : 0;
                                eb2 = k_rs2(kb) ? s2 : 0;
                                raw = erd != 0 && (eb1 == erd || eb2 == erd);
                                waw = erd != 0 && ebd == erd;
                                ok  = (ka <= 5) && (kb <= 1) && !raw && !waw;
                                if (ka == 7 || kb == 7) tag = "R6 compressed";
                                else if (ka > 5)        tag = "R4 lead class";
                                else if (kb > 1)        tag = "R5 follow class";
                                else if (raw)           tag = "R7 RAW";
                                else if (waw)           tag = "R8 WAW";
                                else if (ra == 0)       tag = "R9 zero dest";
                                else                    tag = "R2 pairable";
                                check(tag, 32'(pair_ok), 32'(ok));
                                check("R3 sweep fields",
                                      {12'h0, lead_rd, follow_rd, follow_rs1, follow_rs2},
                                      {12'h0, 5'(erd), 5'(ebd), 5'(eb1), 5'(eb2)});
                            end

        // R1: reset asserted mid-run clears registered result
        rst = 1;
        apply(1, mk(0, 1, 2, 3), 1, mk(1, 4, 5, 0));
        check("R1 mid-run reset", 32'(pair_ok), 0);
        rst = 0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule